// File: doc/BRIEF.md
# Optical Key Echo and Bypass Recognizer

This block watches a qualified "optical signal present" level and picks out two slow patterns from it. Software is not involved: a neighbouring control machine raises a one-cycle `arm` pulse when it starts sending an insertion key. This block then searches a bounded window for the returned three-part echo of that key: a short dark gap, then a longer lit interval, then a long dark interval. Separately, and at all times, it flags a bypass key, which is a single dark gap of a specific length.

All timing is measured in steps of a slow tick enable (nominally 32.768 kHz) that runs alongside the fast system clock. On each tick the block samples the signal level and extends the length of the current run. When the level flips, the finished run is reported with its polarity and length. Finished and ongoing runs are compared against per-element acceptance windows. The three outputs are single-cycle pulses. The decisions taken on those pulses belong to the surrounding logic.

Top module: `optical_key_recognizer`

## Requirements
- R1: After a synchronous active-high reset all three outputs are low, and neither `echo_hit` nor `echo_timeout` pulses before the first `arm`.
- R2: The first echo element is a dark run (`sig_ok`=0) whose length is 25 to 29 ticks inclusive. Length is the number of ticks on which the sampled level held. The run is judged when it ends. Runs of 24 or 30 ticks are not accepted.
- R3: After an accepted first element, the following lit run must last 50 to 59 ticks inclusive.
- R4: After an accepted second element, `echo_hit` pulses once the following dark run reaches 50 ticks. The pulse is registered on the clock edge after the edge that samples the 50th dark tick.
- R5: A run that fails its window restarts matching at the first element without resetting the search window. A dark run that ends short during the third element is itself judged as a candidate first element.
- R6: Without a match, `echo_timeout` pulses on the 3277th tick after `arm`. A new `arm` restarts both the tick count and the matching.
- R7: After `echo_hit` or `echo_timeout`, neither output pulses again until the next `arm`.
- R8: `bypass_hit` pulses when a dark run of 131 to 147 ticks inclusive ends, whether or not the block is armed. Runs of 130 ticks, 148 ticks, or longer than the 255-tick length counter are rejected.
- R9: Every output is high for one cycle at a time, and `echo_hit` and `echo_timeout` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Slow sampling enable, one clock wide |
| sig_ok | input | 1 | Qualified optical signal level, 1 = lit |
| arm | input | 1 | One-cycle pulse that opens a new echo search |
| echo_hit | output | 1 | Pulse: full echo recognized |
| echo_timeout | output | 1 | Pulse: search window expired without echo |
| bypass_hit | output | 1 | Pulse: bypass-length dark run ended |

## Verification
The checker takes `arm` as a pulse seen by the block on the cycle it is high. Its tracked "armed" flag is set by `arm` and cleared by either echo result. It therefore relies on the block treating `arm` as overriding any result computed in the same cycle. The stimulus spaces ticks four clocks apart and places `arm` only on cycles that do not directly follow a tick. This way no result is ever computed in the same cycle as an `arm`, and the bench's tick-level reference model stays exact to the cycle.

// File: rtl/okey_pkg.sv
package okey_pkg;

    // width of the run-length counter; runs longer than its range saturate
    localparam int LEN_W = 8;
    localparam logic [LEN_W-1:0] LEN_MAX = '1;

    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_GAP1 = 2'd1,
        M_LIT2 = 2'd2,
        M_GAP3 = 2'd3
    } match_st_e;

    // registered view of the signal runs, one step per sampled tick
    typedef struct packed {
        logic             step;     // a tick was sampled on the previous edge
        logic             ended;    // the level flipped at that step
        logic             end_lvl;  // level of the run that just finished
        logic [LEN_W-1:0] end_len;  // length of the run that just finished
        logic             cur_lvl;  // level of the run in progress
        logic [LEN_W-1:0] cur_len;  // length of the run in progress
    } run_view_t;

    function automatic logic len_in(input logic [LEN_W-1:0] len,
                                    input logic [LEN_W-1:0] lo,
                                    input logic [LEN_W-1:0] hi);
        return (len >= lo) && (len <= hi);
    endfunction

    function automatic logic [LEN_W-1:0] len_sat_inc(input logic [LEN_W-1:0] len);
        return (len == LEN_MAX) ? len : len + 1'b1;
    endfunction

endpackage

// File: rtl/okey_run_meter.sv
module okey_run_meter
    import okey_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      sig_ok,
    output run_view_t runs
);

    always_ff @(posedge clk) begin
        if (rst) begin
            runs.step    <= 1'b0;
            runs.ended   <= 1'b0;
            runs.end_lvl <= 1'b1;
            runs.end_len <= '0;
            runs.cur_lvl <= 1'b1;
            runs.cur_len <= '0;
        end else begin
            runs.step  <= tick;
            runs.ended <= 1'b0;
            if (tick) begin
                if (sig_ok == runs.cur_lvl) begin
                    runs.cur_len <= len_sat_inc(runs.cur_len);
                end else begin
                    runs.ended   <= 1'b1;
                    runs.end_lvl <= runs.cur_lvl;
                    runs.end_len <= runs.cur_len;
                    runs.cur_lvl <= sig_ok;
                    runs.cur_len <= LEN_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/okey_bypass_detect.sv
module okey_bypass_detect
    import okey_pkg::*;
#(
    parameter int BYP_MIN = 131,
    parameter int BYP_MAX = 147
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             ended,
    input  logic             end_lvl,
    input  logic [LEN_W-1:0] end_len,
    output logic             bypass_hit
);

    localparam logic [LEN_W-1:0] LO = LEN_W'(BYP_MIN);
    localparam logic [LEN_W-1:0] HI = LEN_W'(BYP_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            bypass_hit <= 1'b0;
        end else begin
            bypass_hit <= step && ended && !end_lvl && len_in(end_len, LO, HI);
        end
    end

endmodule

// File: rtl/okey_echo_matcher.sv
module okey_echo_matcher
    import okey_pkg::*;
#(
    parameter int GAP1_MIN     = 25,
    parameter int GAP1_MAX     = 29,
    parameter int LIT2_MIN     = 50,
    parameter int LIT2_MAX     = 59,
    parameter int GAP3_MIN     = 50,
    parameter int WINDOW_TICKS = 3277
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      arm,
    input  run_view_t runs,
    output logic      echo_hit,
    output logic      echo_timeout
);

    localparam int TMR_W = $clog2(WINDOW_TICKS + 1);
    localparam logic [LEN_W-1:0] G1_LO = LEN_W'(GAP1_MIN);
    localparam logic [LEN_W-1:0] G1_HI = LEN_W'(GAP1_MAX);
    localparam logic [LEN_W-1:0] L2_LO = LEN_W'(LIT2_MIN);
    localparam logic [LEN_W-1:0] L2_HI = LEN_W'(LIT2_MAX);
    localparam logic [LEN_W-1:0] G3_LO = LEN_W'(GAP3_MIN);
    localparam logic [TMR_W-1:0] T_END = TMR_W'(WINDOW_TICKS);

    match_st_e        st_q, st_n;
    logic [TMR_W-1:0] tmr_q, tmr_n;
    logic             hit_n, to_n;
    logic             gap_fits_first;

    // a finished dark run that would open a fresh echo
    assign gap_fits_first = runs.ended && !runs.end_lvl && len_in(runs.end_len, G1_LO, G1_HI);

    always_comb begin
        st_n  = st_q;
        tmr_n = tmr_q;
        hit_n = 1'b0;
        to_n  = 1'b0;
        if (arm) begin
            st_n  = M_GAP1;
            tmr_n = '0;
        end else if (st_q != M_IDLE && runs.step) begin
            tmr_n = tmr_q + 1'b1;
            unique case (st_q)
                M_GAP1: begin
                    if (gap_fits_first) st_n = M_LIT2;
                end
                M_LIT2: begin
                    if (runs.ended) begin
                        st_n = (runs.end_lvl && len_in(runs.end_len, L2_LO, L2_HI))
                               ? M_GAP3 : M_GAP1;
                    end
                end
                M_GAP3: begin
                    if (!runs.cur_lvl && runs.cur_len >= G3_LO) begin
                        hit_n = 1'b1;
                        st_n  = M_IDLE;
                    end else if (runs.ended) begin
                        st_n = gap_fits_first ? M_LIT2 : M_GAP1;
                    end
                end
                default: st_n = M_IDLE;
            endcase
            if (!hit_n && tmr_n == T_END) begin
                to_n = 1'b1;
                st_n = M_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= M_IDLE;
            tmr_q        <= '0;
            echo_hit     <= 1'b0;
            echo_timeout <= 1'b0;
        end else begin
            st_q         <= st_n;
            tmr_q        <= tmr_n;
            echo_hit     <= hit_n;
            echo_timeout <= to_n;
        end
    end

endmodule

// File: rtl/optical_key_recognizer.sv
module optical_key_recognizer
    import okey_pkg::*;
#(
    parameter int GAP1_MIN     = 25,
    parameter int GAP1_MAX     = 29,
    parameter int LIT2_MIN     = 50,
    parameter int LIT2_MAX     = 59,
    parameter int GAP3_MIN     = 50,
    parameter int BYP_MIN      = 131,
    parameter int BYP_MAX      = 147,
    parameter int WINDOW_TICKS = 3277
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic sig_ok,
    input  logic arm,
    output logic echo_hit,
    output logic echo_timeout,
    output logic bypass_hit
);

    run_view_t runs;

    okey_run_meter u_meter (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .sig_ok (sig_ok),
        .runs   (runs)
    );

    okey_echo_matcher #(
        .GAP1_MIN     (GAP1_MIN),
        .GAP1_MAX     (GAP1_MAX),
        .LIT2_MIN     (LIT2_MIN),
        .LIT2_MAX     (LIT2_MAX),
        .GAP3_MIN     (GAP3_MIN),
        .WINDOW_TICKS (WINDOW_TICKS)
    ) u_echo (
        .clk          (clk),
        .rst          (rst),
        .arm          (arm),
        .runs         (runs),
        .echo_hit     (echo_hit),
        .echo_timeout (echo_timeout)
    );

    okey_bypass_detect #(
        .BYP_MIN (BYP_MIN),
        .BYP_MAX (BYP_MAX)
    ) u_bypass (
        .clk        (clk),
        .rst        (rst),
        .step       (runs.step),
        .ended      (runs.ended),
        .end_lvl    (runs.end_lvl),
        .end_len    (runs.end_len),
        .bypass_hit (bypass_hit)
    );

endmodule

// File: rtl/okey_checker.sv
module okey_checker (
    input logic clk,
    input logic rst,
    input logic arm,
    input logic echo_hit,
    input logic echo_timeout,
    input logic bypass_hit
);

    // tracks, from the ports alone, whether a search is open
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst)                          armed_q <= 1'b0;
        else if (arm)                     armed_q <= 1'b1;
        else if (echo_hit || echo_timeout) armed_q <= 1'b0;
    end

    // R9: the two search results exclude each other
    a_r9_result_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({echo_hit, echo_timeout}));

    // R7: an echo needs an open search
    a_r7_echo_needs_arm: assert property (@(posedge clk) disable iff (rst)
        echo_hit |-> armed_q);

    // R7: a timeout needs an open search
    a_r7_timeout_needs_arm: assert property (@(posedge clk) disable iff (rst)
        echo_timeout |-> armed_q);

    // R9: pulses last one cycle
    a_r9_echo_pulse: assert property (@(posedge clk) disable iff (rst)
        echo_hit |=> !echo_hit);

    a_r9_timeout_pulse: assert property (@(posedge clk) disable iff (rst)
        echo_timeout |=> !echo_timeout);

    a_r9_bypass_pulse: assert property (@(posedge clk) disable iff (rst)
        bypass_hit |=> !bypass_hit);

endmodule

bind optical_key_recognizer okey_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .arm          (arm),
    .echo_hit     (echo_hit),
    .echo_timeout (echo_timeout),
    .bypass_hit   (bypass_hit)
);

// File: tb/optical_key_recognizer_tb.sv
module optical_key_recognizer_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic sig_ok = 1'b1;
    logic arm = 1'b0;
    logic echo_hit, echo_timeout, bypass_hit;

    always #2 clk = ~clk;   // 250 MHz

    optical_key_recognizer u_dut (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .sig_ok       (sig_ok),
        .arm          (arm),
        .echo_hit     (echo_hit),
        .echo_timeout (echo_timeout),
        .bypass_hit   (bypass_hit)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // behavioural reference: runs measured in ticks, search state as a number
    int  m_lvl = 1, m_len = 0;
    int  m_stage = 0;        // 0 closed, 1..3 element awaited
    int  m_ticks = 0;
    bit  m_pend = 0, m_pend_s = 1;
    int  n_echo = 0, n_to = 0, n_byp = 0;

    function automatic bit inr(int v, int lo, int hi);
        return v >= lo && v <= hi;
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input bit t, input bit s, input bit a);
        bit e_echo = 0, e_to = 0, e_byp = 0;
        @(negedge clk);
        tick = t; sig_ok = s; arm = a;
        if (m_pend) begin
            bit ended = 0; int elen = 0, elev = 0;
            if (m_pend_s == m_lvl) m_len = (m_len < 255) ? m_len + 1 : 255;
            else begin ended = 1; elen = m_len; elev = m_lvl; m_lvl = m_pend_s; m_len = 1; end
            e_byp = ended && elev == 0 && inr(elen, 131, 147);
            if (a) begin m_stage = 1; m_ticks = 0; end
            else if (m_stage != 0) begin
                m_ticks++;
                if (m_stage == 1) begin
                    if (ended && elev == 0 && inr(elen, 25, 29)) m_stage = 2;
                end else if (m_stage == 2) begin
                    if (ended) m_stage = (elev == 1 && inr(elen, 50, 59)) ? 3 : 1;
                end else begin
                    if (m_lvl == 0 && m_len >= 50) begin e_echo = 1; m_stage = 0; end
                    else if (ended) m_stage = (elev == 0 && inr(elen, 25, 29)) ? 2 : 1;
                end
                if (!e_echo && m_ticks == 3277) begin e_to = 1; m_stage = 0; end
            end
        end else if (a) begin
            m_stage = 1; m_ticks = 0;
        end
        m_pend = t; m_pend_s = s;
        @(posedge clk);
        #1;
        check("R4", echo_hit, e_echo, "echo_hit per cycle");
        check("R6", echo_timeout, e_to, "echo_timeout per cycle");
        check("R8", bypass_hit, e_byp, "bypass_hit per cycle");
        n_echo += echo_hit; n_to += echo_timeout; n_byp += bypass_hit;
    endtask

    task automatic run(input bit s, input int n);
        for (int i = 0; i < n; i++) begin
            cyc(1, s, 0); cyc(0, s, 0); cyc(0, s, 0); cyc(0, s, 0);
        end
    endtask

    task automatic do_arm();
        cyc(0, sig_ok, 1);
        cyc(0, sig_ok, 0);
    endtask

    task automatic clr();
        n_echo = 0; n_to = 0; n_byp = 0;
    endtask

    task automatic expect_n(string tag, int e, int t, int b);
        check(tag, n_echo, e, "echo count");
        check(tag, n_to, t, "timeout count");
        check(tag, n_byp, b, "bypass count");
        clr();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: quiet after reset
        check("R1", echo_hit, 0, "echo after reset");
        check("R1", echo_timeout, 0, "timeout after reset");
        check("R1", bypass_hit, 0, "bypass after reset");

        // R1: echo pattern before any arm gives nothing
        run(1, 10); run(0, 27); run(1, 55); run(0, 60); run(1, 5);
        expect_n("R1", 0, 0, 0);

        // R8: bypass windows, unarmed
        run(0, 140); run(1, 10); expect_n("R8", 0, 0, 1);
        run(0, 130); run(1, 10); expect_n("R8", 0, 0, 0);
        run(0, 148); run(1, 10); expect_n("R8", 0, 0, 0);
        run(0, 131); run(1, 10); expect_n("R8", 0, 0, 1);
        run(0, 147); run(1, 10); expect_n("R8", 0, 0, 1);
        run(0, 300); run(1, 10); expect_n("R8", 0, 0, 0);

        // R4: nominal echo
        do_arm(); run(0, 27); run(1, 55); run(0, 60); run(1, 5);
        expect_n("R4", 1, 0, 0);
        // R7: repeated pattern without a new arm is ignored
        run(0, 27); run(1, 55); run(0, 50); run(1, 5);
        expect_n("R7", 0, 0, 0);

        // R2 and R3: lower bounds, then upper bounds
        do_arm(); run(0, 25); run(1, 50); run(0, 50); run(1, 5);
        expect_n("R2", 1, 0, 0);
        do_arm(); run(0, 29); run(1, 59); run(0, 50); run(1, 5);
        expect_n("R3", 1, 0, 0);

        // R2: first element too short / too long, then recovery inside window (R5)
        do_arm(); run(0, 24); run(1, 55); run(0, 60); run(1, 5);
        run(0, 30); run(1, 55); run(0, 60); run(1, 5);
        expect_n("R2", 0, 0, 0);
        run(0, 27); run(1, 55); run(0, 50); run(1, 5);
        expect_n("R5", 1, 0, 0);

        // R3: second element too short then too long, third attempt good
        do_arm(); run(0, 27); run(1, 49); run(0, 27); run(1, 60);
        run(0, 27); run(1, 55); run(0, 50); run(1, 5);
        expect_n("R3", 1, 0, 0);

        // R5: short third gap reused as a first element
        do_arm(); run(0, 27); run(1, 55); run(0, 26); run(1, 52); run(0, 50); run(1, 5);
        expect_n("R5", 1, 0, 0);

        // R6: timeout exactly on tick 3277
        do_arm(); run(1, 3276);
        expect_n("R6", 0, 0, 0);
        run(1, 1); cyc(0, 1, 0);
        expect_n("R6", 0, 1, 0);
        // R7: no further results after timeout
        run(0, 27); run(1, 55); run(0, 50); run(1, 5);
        expect_n("R7", 0, 0, 0);

        // R6: re-arm restarts the count
        do_arm(); run(1, 3000); do_arm(); run(1, 3276);
        expect_n("R6", 0, 0, 0);
        run(1, 1); cyc(0, 1, 0);
        expect_n("R6", 0, 1, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule